// File: doc/BRIEF.md
# Aliasing Internal Register Decoder

This block sits between a byte-wide internal bus master (a host bridge or a start-up loader) and the register targets behind it. It turns one 8-bit internal address and a read or write strobe into a select for exactly one target. The targets are a global configuration region, eight serial channels with ten registers each, and one shared interrupt status register. Read data from the selected target is captured and returned on the next cycle.

The upper half of the map is split into two parts. 80h–BFh gives each channel an 8-register window. C0h–FFh packs each channel's two extended registers into pairs. Inside C0h–FFh, address bits 5:4 are not decoded. Inside 40h–7Fh, address bit 5 is not decoded. The decoder owns two small control registers: a per-channel enable byte and a shared-status enable bit. A channel whose enable bit is low is treated as absent. When the shared-status enable is set, the shared status register claims slot 0 of the extended range ahead of channel 0's register 8.

Top module: `intreg_decode`

## Requirements
- R1: Addresses 00h–7Fh, other than the two control registers, select the configuration region: `cfg_rd`/`cfg_wr` follow `rd`/`wr` and `cfg_addr` carries the address. In 40h–7Fh, bit 5 is forced to 0, so 60h–7Fh reach the same targets as 40h–5Fh.
- R2: The channel-enable register sits at 40h (alias 60h). It is written with the full data byte and read back unchanged. It resets to 00h. Its bit n enables channel n and appears on `chan_en`.
- R3: The shared-status enable sits at 42h (alias 62h). It is written from data bit 7 and reads back as {enable, 7'b0}. It resets to 1 (reads as 80h).
- R4: Address 80h+8n+r, with r in 0–7, raises bit n of `ch_rd`/`ch_wr` and sets `ch_reg`=r.
- R5: In C0h–FFh, address bits 5:4 are ignored. Low nibble 2n+k, with k in 0–1, selects channel n with `ch_reg`=8+k.
- R6: While the shared-status enable is 1, low nibble 0 in C0h–FFh selects the shared status register and no channel. A read raises `ss_rd` and returns `ss_rdata`; a write raises no strobe. While the enable is 0, the slot belongs to channel 0, register 8.
- R7: An access to a channel whose enable bit is 0 raises no strobe, and a read of it returns 00h.
- R8: `rvalid` is high exactly in the cycle after a cycle with `rd` high. `rdata` then holds the selected target's data as sampled in the `rd` cycle. `rdata` is 00h whenever `rvalid` is low.
- R9: Strobes are combinational in the same cycle as `rd`/`wr`. At most one strobe bit among all targets is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Internal address |
| rd | input | 1 | Read strobe, one cycle per access |
| wr | input | 1 | Write strobe, one cycle per access |
| wdata | input | 8 | Write data |
| cfg_rd | output | 1 | Configuration region read select |
| cfg_wr | output | 1 | Configuration region write select |
| cfg_addr | output | 7 | Aliased configuration address |
| cfg_rdata | input | 8 | Configuration region read data |
| ch_rd | output | 8 | Per-channel read select |
| ch_wr | output | 8 | Per-channel write select |
| ch_reg | output | 4 | Register index within channel (0–9) |
| ch_rdata | input | 64 | Channel read data, channel n in bits 8n+7:8n |
| ss_rd | output | 1 | Shared status register read select |
| ss_rdata | input | 8 | Shared status register data |
| chan_en | output | 8 | Channel-enable register |
| shr_en | output | 1 | Shared-status enable |
| rdata | output | 8 | Registered read data |
| rvalid | output | 1 | Read data valid |

## Verification
The bench aims at the aliased addresses: 60h-range control registers, 75h, and the D-, E- and F-row extended slots. A decoder that decoded the ignored bits would leave those accesses unselected or would misroute them. It also toggles the shared-status enable around C0h. A design with the priority wrong would strobe channel 0 alongside the shared register, or would hide register 8 of channel 0 when it is disabled. With one channel disabled, it reads from that channel's main and extended slots to catch a leaked strobe or stale nonzero data. It also checks the read pipeline, since a returned value one cycle early or late misaligns the scoreboard.

// File: rtl/intreg_decode.sv
module intreg_decode #(
  parameter logic [7:0] CH_EN_RST = 8'h00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  addr,
  input  logic        rd,
  input  logic        wr,
  input  logic [7:0]  wdata,
  output logic        cfg_rd,
  output logic        cfg_wr,
  output logic [6:0]  cfg_addr,
  input  logic [7:0]  cfg_rdata,
  output logic [7:0]  ch_rd,
  output logic [7:0]  ch_wr,
  output logic [3:0]  ch_reg,
  input  logic [63:0] ch_rdata,
  output logic        ss_rd,
  input  logic [7:0]  ss_rdata,
  output logic [7:0]  chan_en,
  output logic        shr_en,
  output logic [7:0]  rdata,
  output logic        rvalid
);
  localparam int NCH = 8;

  logic       low_half, ctl_row, en_hit, sen_hit, cfg_hit;
  logic       main_win, ext_win, ss_hit, ch_hit;
  logic [2:0] ch_idx;
  logic [7:0] ch_onehot, rd_mux;

  assign low_half = ~addr[7];
  assign ctl_row  = addr[7:6] == 2'b01;
  assign en_hit   = ctl_row && addr[4:0] == 5'h00;
  assign sen_hit  = ctl_row && addr[4:0] == 5'h02;
  assign cfg_hit  = low_half && !en_hit && !sen_hit;
  assign cfg_addr = addr[6] ? {2'b10, addr[4:0]} : addr[6:0];

  assign main_win = addr[7:6] == 2'b10;
  assign ext_win  = addr[7:6] == 2'b11;
  assign ss_hit   = ext_win && shr_en && addr[3:0] == 4'h0;
  assign ch_idx   = main_win ? addr[5:3] : addr[3:1];
  assign ch_reg   = main_win ? {1'b0, addr[2:0]} : {3'b100, addr[0]};
  assign ch_hit   = (main_win || (ext_win && !ss_hit)) && chan_en[ch_idx];
  assign ch_onehot = ch_hit ? (8'b1 << ch_idx) : 8'b0;

  assign cfg_rd = cfg_hit && rd;
  assign cfg_wr = cfg_hit && wr;
  assign ss_rd  = ss_hit && rd;
  assign ch_rd  = rd ? ch_onehot : 8'b0;
  assign ch_wr  = wr ? ch_onehot : 8'b0;

  always_comb begin
    rd_mux = 8'h00;
    if (cfg_hit)      rd_mux = cfg_rdata;
    else if (en_hit)  rd_mux = chan_en;
    else if (sen_hit) rd_mux = {shr_en, 7'b0};
    else if (ss_hit)  rd_mux = ss_rdata;
    else if (ch_hit)  rd_mux = ch_rdata[ch_idx*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chan_en <= CH_EN_RST;
      shr_en  <= 1'b1;
      rdata   <= 8'h00;
      rvalid  <= 1'b0;
    end else begin
      if (wr && en_hit)  chan_en <= wdata;
      if (wr && sen_hit) shr_en  <= wdata[7];
      rvalid <= rd;
      rdata  <= rd ? rd_mux : 8'h00;
    end
  end

  p_one_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cfg_rd, cfg_wr, ss_rd, ch_rd, ch_wr}));
  p_rd_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rvalid);
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid |-> rdata == 8'h00);
  p_disabled_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && main_win && !chan_en[addr[5:3]]) |=> rdata == 8'h00);
  p_shared_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && ext_win && shr_en && addr[3:0] == 4'h0) |-> ss_rd && ch_rd == 8'b0);
  p_no_rdwr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd && wr));
endmodule

// File: tb/intreg_decode_tb.sv
module intreg_decode_tb;
  logic        clk = 0, rst_n = 0;
  logic [7:0]  addr = 0, wdata = 0;
  logic        rd = 0, wr = 0;
  logic        cfg_rd, cfg_wr, ss_rd, shr_en, rvalid;
  logic [6:0]  cfg_addr;
  logic [7:0]  cfg_rdata, ch_rd, ch_wr, chan_en, rdata;
  logic [3:0]  ch_reg;
  logic [63:0] ch_rdata;
  logic [7:0]  ss_rdata = 8'h5A;
  int checks = 0, fails = 0;
  logic [7:0]  expq[$];
  string       tagq[$];

  always #2 clk = ~clk;

  intreg_decode u_dut (.clk, .rst_n, .addr, .rd, .wr, .wdata, .cfg_rd, .cfg_wr,
    .cfg_addr, .cfg_rdata, .ch_rd, .ch_wr, .ch_reg, .ch_rdata, .ss_rd, .ss_rdata,
    .chan_en, .shr_en, .rdata, .rvalid);

  assign cfg_rdata = {1'b0, cfg_addr};
  always_comb
    for (int i = 0; i < 8; i++) ch_rdata[i*8 +: 8] = {1'b1, 3'(i), ch_reg};

  task automatic chk(input string tag, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // strobe vector: {cfg_rd, cfg_wr, ss_rd, ch_rd, ch_wr}
  task automatic acc(input bit w, input logic [7:0] a, d, input logic [18:0] strb,
                     input logic [6:0] ecfg, input logic [3:0] ereg,
                     input logic [7:0] erd, input string tag);
    @(negedge clk);
    addr = a; wdata = d; rd = !w; wr = w;
    #1;
    chk({tag, " strobes"}, {cfg_rd, cfg_wr, ss_rd, ch_rd, ch_wr}, strb);
    if (strb[18:17] != 0) chk({tag, " cfg_addr"}, cfg_addr, ecfg);
    if (strb[15:0] != 0) chk({tag, " ch_reg"}, ch_reg, ereg);
    if (!w) begin expq.push_back(erd); tagq.push_back(tag); end
    @(negedge clk);
    rd = 0; wr = 0;
  endtask

  always @(negedge clk) if (rst_n) begin
    if (rvalid) begin
      if (expq.size() == 0) chk("R8 unexpected rvalid", 1, 0);
      else chk({tagq.pop_front(), " rdata"}, rdata, expq.pop_front());
    end else chk("R8 idle rdata", rdata, 0);
  end

  initial begin
    #2000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1;
    chk("R2 reset chan_en", chan_en, 8'h00);
    chk("R3 reset shr_en", shr_en, 1);
    chk("R8 reset rvalid", rvalid, 0);
    acc(0, 8'h80, 0, 19'h0, 0, 0, 8'h00, "R7 disabled ch0 read");
    acc(1, 8'h40, 8'hA5, 19'h0, 0, 0, 0, "R2 write enable");
    chk("R2 chan_en after write", chan_en, 8'hA5);
    acc(0, 8'h40, 0, 19'h0, 0, 0, 8'hA5, "R2 read enable");
    acc(0, 8'h60, 0, 19'h0, 0, 0, 8'hA5, "R1 aliased enable read");
    acc(0, 8'h42, 0, 19'h0, 0, 0, 8'h80, "R3 read shared enable");
    acc(1, 8'h60, 8'hFF, 19'h0, 0, 0, 0, "R1 aliased enable write");
    chk("R1 chan_en via alias", chan_en, 8'hFF);
    acc(0, 8'h93, 0, {3'b000, 8'h04, 8'h00}, 0, 3, 8'hA3, "R4 ch2 reg3 read");
    acc(1, 8'hBF, 8'h77, {3'b000, 8'h00, 8'h80}, 0, 7, 0, "R4 ch7 reg7 write");
    acc(0, 8'h13, 0, {3'b100, 16'h0}, 7'h13, 0, 8'h13, "R1 cfg read 13h");
    acc(0, 8'h75, 0, {3'b100, 16'h0}, 7'h55, 0, 8'h55, "R1 cfg alias 75h");
    acc(1, 8'h41, 8'h11, {3'b010, 16'h0}, 7'h41, 0, 0, "R1 cfg write 41h");
    acc(0, 8'hC0, 0, {3'b001, 16'h0}, 0, 0, 8'h5A, "R6 shared read C0h");
    acc(0, 8'hF0, 0, {3'b001, 16'h0}, 0, 0, 8'h5A, "R6 shared alias F0h");
    acc(1, 8'hC0, 8'h33, 19'h0, 0, 0, 0, "R6 shared write ignored");
    acc(0, 8'hC1, 0, {3'b000, 8'h01, 8'h00}, 0, 9, 8'h89, "R5 ch0 reg9");
    acc(0, 8'hD7, 0, {3'b000, 8'h08, 8'h00}, 0, 9, 8'hB9, "R5 alias D7h ch3 reg9");
    acc(1, 8'hEE, 8'h01, {3'b000, 8'h00, 8'h80}, 0, 8, 0, "R5 alias EEh ch7 reg8");
    acc(1, 8'h62, 8'h00, 19'h0, 0, 0, 0, "R3 clear shared enable");
    chk("R3 shr_en cleared", shr_en, 0);
    acc(0, 8'h42, 0, 19'h0, 0, 0, 8'h00, "R3 read shared enable off");
    acc(0, 8'hC0, 0, {3'b000, 8'h01, 8'h00}, 0, 8, 8'h88, "R6 C0h to ch0 reg8");
    acc(1, 8'h40, 8'hFB, 19'h0, 0, 0, 0, "R7 disable ch2");
    acc(0, 8'h95, 0, 19'h0, 0, 0, 8'h00, "R7 disabled ch2 main read");
    acc(1, 8'h90, 8'h44, 19'h0, 0, 0, 0, "R7 disabled ch2 write");
    acc(0, 8'hC4, 0, 19'h0, 0, 0, 8'h00, "R7 disabled ch2 ext read");
    acc(0, 8'hC6, 0, {3'b000, 8'h08, 8'h00}, 0, 8, 8'hB8, "R9 ch3 reg8 neighbour");
    repeat (3) @(negedge clk);
    chk("R8 scoreboard drained", expq.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule